// File: doc/BRIEF.md
# Exception Vector Fetch Catch Detector

This block watches the instruction-fetch stream of a 32-bit core and raises a debug event when a fetch lands on a guarded entry of an exception vector table. Each fetch address is compared with up to two tables: the normal table, whose base is either the fixed high address 0xFFFF0000 or a programmable base, and the secure-monitor table, whose base is a second programmable register. A hit selects one of eight vector slots. The slot index, the security state and the monitor configuration choose one bit of a 32-bit catch word. That bit is then qualified by a software-written control register and by a configuration mask.

The result is a one-cycle catch pulse and the index of the vector slot that matched, both registered one clock after the fetch is presented. A debug-enable input gates the whole function. An abort-vector catch that would route the debug exception back to the level already executing is suppressed, because the outcome of that case is not defined.

Top module: `vc_addr_match`

## Requirements
- R1: While `rst_n` is low and after reset is released, `catch_o` is 0 and `slot_o` is 0 until a qualifying fetch has been sampled.
- R2: A fetch is considered only when `fetch_vld` and `dbg_en` are both 1 at the clock edge. Otherwise `catch_o` stays 0 on the next cycle.
- R3: No catch is raised when `fetch_addr[1:0]` is nonzero, or when `cur_el` equals 2 (the hypervisor level, with encoding 0..3 for levels 0..3).
- R4: The normal table base is 0xFFFF0000 when `hivec` is 1, and otherwise `vbase` with bits 4:0 cleared. A fetch hits a table when `fetch_addr` with bits 4:0 cleared equals that base. The slot index is `fetch_addr[4:2]`.
- R5: On a normal-table hit, the candidate catch-word bit is slot+24 when `mon_present` is 1 and `cur_secure` is 0. In every other case it is bit slot.
- R6: When `mon_present`, `mon_is32` and `cur_secure` are all 1 and the address hits the `mvbase` table (bits 4:0 cleared), bit slot+8 is also a candidate.
- R7: Candidates are ANDed with `vc_ctrl` and with a mask. The mask is 0x000000DE without a monitor level, 0xDE0000DE with a 64-bit monitor level, and 0xDE00DEDE with a 32-bit monitor level. Slots 0 and 5 therefore never catch.
- R8: A catch is raised when the masked word is nonzero. It is suppressed when the masked word includes an abort slot (slot 3 or 4, word mask 0x18001818) and `dbg_tgt_el` equals `cur_el`.
- R9: `catch_o` is 1 for exactly the cycle after a catching fetch, and `slot_o` then carries its slot. `slot_o` is 0 whenever `catch_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Global debug enable |
| fetch_vld | input | 1 | Fetch address valid strobe |
| fetch_addr | input | 32 | Instruction fetch virtual address |
| cur_el | input | 2 | Current exception level (2 = hypervisor) |
| cur_secure | input | 1 | Core is in secure state |
| mon_present | input | 1 | A secure monitor level exists |
| mon_is32 | input | 1 | Monitor level runs in 32-bit mode |
| hivec | input | 1 | High vectors selected |
| vbase | input | 32 | Normal vector base register |
| mvbase | input | 32 | Monitor vector base register |
| vc_ctrl | input | 32 | Vector catch control word |
| dbg_tgt_el | input | 2 | Level that debug exceptions target |
| catch_o | output | 1 | Registered catch pulse |
| slot_o | output | 3 | Slot of the caught vector, 0 when idle |

## Verification
The assertions check on every cycle the properties that need no table lookup. A catch is never raised without a valid enabled, aligned, non-hypervisor fetch one cycle earlier. The slot output is zero when idle and never names the masked-off slots 0 and 5. No abort-slot catch is raised when the debug target matched the current level. Which catch-word bit a given security and monitor configuration selects, and whether the base comparison honours the high-vector choice, can only be shown by the bench's scenarios. These are directed table hits and random fetches aimed near the programmed bases, compared against an independent model.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int unsigned VC_W      = 32;
  localparam int unsigned SLOT_W    = 3;
  localparam int unsigned N_SLOTS   = 1 << SLOT_W;
  localparam int unsigned EL_W      = 2;
  localparam logic [EL_W-1:0] EL_HYP = 2'd2;

  localparam int unsigned OFS_SEC   = 0;
  localparam int unsigned OFS_MON   = 8;
  localparam int unsigned OFS_NSEC  = 24;

  localparam logic [VC_W-1:0] MASK_NOMON = 32'h0000_00DE;
  localparam logic [VC_W-1:0] MASK_MON64 = 32'hDE00_00DE;
  localparam logic [VC_W-1:0] MASK_MON32 = 32'hDE00_DEDE;
  localparam logic [VC_W-1:0] ABORT_BITS = 32'h1800_1818;

  typedef struct packed {
    logic            fire;
    logic [SLOT_W-1:0] slot;
  } vc_result_t;
endpackage

// File: rtl/vc_base_sel.sv
module vc_base_sel #(
  parameter int unsigned AW      = 32,
  parameter int unsigned ALIGN_W = 5,
  parameter logic [AW-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic          hivec,
  input  logic [AW-1:0] vbase,
  input  logic [AW-1:0] mvbase,
  output logic [AW-1:0] norm_base,
  output logic [AW-1:0] mon_base
);
  localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ALIGN_W) - AW'(1));

  always_comb begin
    if (hivec) norm_base = HI_BASE;
    else       norm_base = vbase & ALIGN_MASK;
    mon_base = mvbase & ALIGN_MASK;
  end
endmodule

// File: rtl/vc_word_build.sv
module vc_word_build
  import vc_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned ALIGN_W = 5
) (
  input  logic [AW-1:0]     addr,
  input  logic [AW-1:0]     norm_base,
  input  logic [AW-1:0]     mon_base,
  input  logic              cur_secure,
  input  logic              mon_present,
  input  logic              mon_is32,
  output logic [VC_W-1:0]   word,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ALIGN_W) - AW'(1));

  logic [AW-1:0]      blk;
  logic               hit_norm;
  logic               hit_mon;
  logic               use_nsec;
  logic [N_SLOTS-1:0] slot_dec;

  assign blk      = addr & ALIGN_MASK;
  assign slot     = addr[SLOT_W+1:2];
  assign hit_norm = (blk == norm_base);
  assign hit_mon  = (blk == mon_base) && mon_present && mon_is32 && cur_secure;
  assign use_nsec = mon_present && !cur_secure;

  generate
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_dec
      assign slot_dec[g] = (slot == SLOT_W'(g));
    end
  endgenerate

  always_comb begin
    word = '0;
    if (hit_norm) begin
      if (use_nsec) word[OFS_NSEC +: N_SLOTS] = slot_dec;
      else          word[OFS_SEC  +: N_SLOTS] = slot_dec;
    end
    if (hit_mon) word[OFS_MON +: N_SLOTS] = word[OFS_MON +: N_SLOTS] | slot_dec;
  end
endmodule

// File: rtl/vc_filter.sv
module vc_filter
  import vc_pkg::*;
(
  input  logic [VC_W-1:0] word,
  input  logic [VC_W-1:0] ctrl,
  input  logic            mon_present,
  input  logic            mon_is32,
  input  logic [EL_W-1:0] cur_el,
  input  logic [EL_W-1:0] tgt_el,
  input  logic            qualify,
  output logic            fire
);
  logic [VC_W-1:0] cfg_mask;
  logic [VC_W-1:0] masked;
  logic            self_abort;

  always_comb begin
    if (!mon_present)  cfg_mask = MASK_NOMON;
    else if (!mon_is32) cfg_mask = MASK_MON64;
    else               cfg_mask = MASK_MON32;
  end

  assign masked     = word & ctrl & cfg_mask;
  assign self_abort = (|(masked & ABORT_BITS)) && (tgt_el == cur_el);
  assign fire       = qualify && (|masked) && !self_abort;
endmodule

// File: rtl/vc_addr_match.sv
module vc_addr_match
  import vc_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned ALIGN_W = 5,
  parameter logic [AW-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dbg_en,
  input  logic                  fetch_vld,
  input  logic [AW-1:0]         fetch_addr,
  input  logic [1:0]            cur_el,
  input  logic                  cur_secure,
  input  logic                  mon_present,
  input  logic                  mon_is32,
  input  logic                  hivec,
  input  logic [AW-1:0]         vbase,
  input  logic [AW-1:0]         mvbase,
  input  logic [31:0]           vc_ctrl,
  input  logic [1:0]            dbg_tgt_el,
  output logic                  catch_o,
  output logic [2:0]            slot_o
);
  logic [AW-1:0]     norm_base;
  logic [AW-1:0]     mon_base;
  logic [VC_W-1:0]   word;
  logic [SLOT_W-1:0] slot;
  logic              qualify;
  logic              fire;
  vc_result_t        res_d;
  vc_result_t        res_q;

  vc_base_sel #(.AW(AW), .ALIGN_W(ALIGN_W), .HI_BASE(HI_BASE)) u_base (
    .hivec     (hivec),
    .vbase     (vbase),
    .mvbase    (mvbase),
    .norm_base (norm_base),
    .mon_base  (mon_base)
  );

  vc_word_build #(.AW(AW), .ALIGN_W(ALIGN_W)) u_word (
    .addr        (fetch_addr),
    .norm_base   (norm_base),
    .mon_base    (mon_base),
    .cur_secure  (cur_secure),
    .mon_present (mon_present),
    .mon_is32    (mon_is32),
    .word        (word),
    .slot        (slot)
  );

  assign qualify = fetch_vld && dbg_en && (fetch_addr[1:0] == 2'b00) && (cur_el != EL_HYP);

  vc_filter u_filt (
    .word        (word),
    .ctrl        (vc_ctrl),
    .mon_present (mon_present),
    .mon_is32    (mon_is32),
    .cur_el      (cur_el),
    .tgt_el      (dbg_tgt_el),
    .qualify     (qualify),
    .fire        (fire)
  );

  always_comb begin
    res_d.fire = fire;
    res_d.slot = fire ? slot : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign catch_o = res_q.fire;
  assign slot_o  = res_q.slot;
endmodule

// File: rtl/vc_addr_match_chk.sv
module vc_addr_match_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dbg_en,
  input logic        fetch_vld,
  input logic [31:0] fetch_addr,
  input logic [1:0]  cur_el,
  input logic [1:0]  dbg_tgt_el,
  input logic        catch_o,
  input logic [2:0]  slot_o
);
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> (catch_o == 1'b0 && slot_o == 3'd0));

  p_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    catch_o |-> $past(fetch_vld && dbg_en));

  p_aligned_nonhyp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    catch_o |-> ($past(fetch_addr[1:0]) == 2'b00 && $past(cur_el) != 2'd2));

  p_masked_slots_r7: assert property (@(posedge clk) disable iff (!rst_n)
    catch_o |-> (slot_o != 3'd0 && slot_o != 3'd5));

  p_abort_self_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (catch_o && (slot_o == 3'd3 || slot_o == 3'd4)) |-> ($past(dbg_tgt_el) != $past(cur_el)));

  p_idle_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !catch_o |-> slot_o == 3'd0);
endmodule

bind vc_addr_match vc_addr_match_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dbg_en     (dbg_en),
  .fetch_vld  (fetch_vld),
  .fetch_addr (fetch_addr),
  .cur_el     (cur_el),
  .dbg_tgt_el (dbg_tgt_el),
  .catch_o    (catch_o),
  .slot_o     (slot_o)
);

// File: tb/vc_addr_match_tb.sv
`timescale 1ns/1ps
module vc_addr_match_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dbg_en, fetch_vld, cur_secure, mon_present, mon_is32, hivec;
  logic [31:0] fetch_addr, vbase, mvbase, vc_ctrl;
  logic [1:0]  cur_el, dbg_tgt_el;
  logic        catch_o;
  logic [2:0]  slot_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vc_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .fetch_vld(fetch_vld),
    .fetch_addr(fetch_addr), .cur_el(cur_el), .cur_secure(cur_secure),
    .mon_present(mon_present), .mon_is32(mon_is32), .hivec(hivec),
    .vbase(vbase), .mvbase(mvbase), .vc_ctrl(vc_ctrl), .dbg_tgt_el(dbg_tgt_el),
    .catch_o(catch_o), .slot_o(slot_o)
  );

  function automatic logic [3:0] model();
    logic [31:0] blk, nb;
    logic [2:0]  s;
    logic        any;
    int          pos;
    if (!fetch_vld || !dbg_en || fetch_addr[1:0] != 2'b00 || cur_el == 2'd2) return 4'd0;
    s   = fetch_addr[4:2];
    blk = {fetch_addr[31:5], 5'd0};
    nb  = hivec ? 32'hFFFF0000 : {vbase[31:5], 5'd0};
    any = 1'b0;
    if (s != 3'd0 && s != 3'd5) begin
      if (blk == nb) begin
        pos = (mon_present && !cur_secure) ? 24 + int'(s) : int'(s);
        if (vc_ctrl[pos]) any = 1'b1;
      end
      if (blk == {mvbase[31:5], 5'd0} && mon_present && mon_is32 && cur_secure)
        if (vc_ctrl[8 + int'(s)]) any = 1'b1;
    end
    if (any && (s == 3'd3 || s == 3'd4) && dbg_tgt_el == cur_el) any = 1'b0;
    return any ? {1'b1, s} : 4'd0;
  endfunction

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got catch=%0b slot=%0d, expected catch=%0b slot=%0d",
               req, got[3], got[2:0], exp[3], exp[2:0]);
    end
  endtask

  task automatic step(string req);
    logic [3:0] exp;
    exp = model();
    @(negedge clk);
    check(req, {catch_o, slot_o}, exp);
  endtask

  task automatic defaults();
    dbg_en = 1'b1; fetch_vld = 1'b1; cur_secure = 1'b1; mon_present = 1'b0;
    mon_is32 = 1'b0; hivec = 1'b0; vbase = 32'h0000_1000; mvbase = 32'h0000_2000;
    vc_ctrl = 32'hFFFF_FFFF; cur_el = 2'd1; dbg_tgt_el = 2'd3; fetch_addr = 32'h0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    defaults();
    fetch_addr = 32'h0000_1004;
    #23;
    check("R1", {catch_o, slot_o}, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    fetch_vld = 1'b0;
    @(negedge clk);
    check("R1", {catch_o, slot_o}, 4'd0);

    // R4 high vectors, slot 1
    defaults(); hivec = 1'b1; fetch_addr = 32'hFFFF_0004; vc_ctrl = 32'h2;
    step("R4");
    check("R4", {catch_o, slot_o}, {1'b1, 3'd1});
    // R4 high vectors ignore vbase
    fetch_addr = 32'h0000_1004; step("R4");
    check("R4", {catch_o, slot_o}, 4'd0);
    // R9 single-cycle pulse
    fetch_vld = 1'b0; step("R9");
    check("R9", {catch_o, slot_o}, 4'd0);
    // R2 debug disabled
    defaults(); dbg_en = 1'b0; fetch_addr = 32'h0000_1008; step("R2");
    check("R2", {catch_o, slot_o}, 4'd0);
    // R3 unaligned and hypervisor
    defaults(); fetch_addr = 32'h0000_100A; step("R3");
    defaults(); fetch_addr = 32'h0000_1008; cur_el = 2'd2; step("R3");
    // R5 non-secure with monitor uses upper byte
    defaults(); mon_present = 1'b1; cur_secure = 1'b0; fetch_addr = 32'h0000_1008;
    vc_ctrl = 32'h0400_0000; step("R5");
    check("R5", {catch_o, slot_o}, {1'b1, 3'd2});
    vc_ctrl = 32'h0000_0004; step("R5");
    check("R5", {catch_o, slot_o}, 4'd0);
    // R6 monitor table
    defaults(); mon_present = 1'b1; mon_is32 = 1'b1; fetch_addr = 32'h0000_2018;
    vc_ctrl = 32'h0000_4000; step("R6");
    check("R6", {catch_o, slot_o}, {1'b1, 3'd6});
    // R7 64-bit monitor masks the monitor byte
    mon_is32 = 1'b0; step("R7");
    check("R7", {catch_o, slot_o}, 4'd0);
    // R7 slot 5 never catches
    defaults(); fetch_addr = 32'h0000_1014; step("R7");
    check("R7", {catch_o, slot_o}, 4'd0);
    // R8 abort slot to same level suppressed, other level caught
    defaults(); fetch_addr = 32'h0000_100C; dbg_tgt_el = 2'd1; step("R8");
    check("R8", {catch_o, slot_o}, 4'd0);
    dbg_tgt_el = 2'd3; step("R8");
    check("R8", {catch_o, slot_o}, {1'b1, 3'd3});

    // Random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] pick;
      dbg_en      = ($urandom % 8) != 0;
      fetch_vld   = ($urandom % 6) != 0;
      cur_secure  = $urandom;
      mon_present = $urandom;
      mon_is32    = $urandom;
      hivec       = ($urandom % 4) == 0;
      vbase       = $urandom;
      mvbase      = ($urandom % 5 == 0) ? vbase : $urandom;
      vc_ctrl     = $urandom;
      cur_el      = $urandom;
      dbg_tgt_el  = $urandom;
      pick        = $urandom;
      case (pick)
        3'd0, 3'd1: fetch_addr = hivec ? 32'hFFFF0000 : {vbase[31:5], 5'd0};
        3'd2, 3'd3: fetch_addr = {mvbase[31:5], 5'd0};
        default:    fetch_addr = $urandom & 32'hFFFF_FFE0;
      endcase
      fetch_addr[4:0] = $urandom;
      if (($urandom % 5) != 0) fetch_addr[1:0] = 2'b00;
      step("R4/R5/R6/R7/R8");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule